// File: doc/BRIEF.md
# Stateful Memory Access Policy Monitor

This block sits beside a shared memory bus and judges every access request against a policy held as a finite automaton. Each request names the requesting module (one of two), whether it reads or writes, and which address range it hits. The range is given as a vector of hit flags that an external decoder produces. For each request the block answers grant or deny one cycle later. Its policy state also moves on, so the rights of each module can change over the course of a run.

In the default stateful variant, two particular writes by module 1 act as triggers. Each trigger is granted and moves the automaton to a new permission set. Once both triggers have occurred, in either order, a final set applies. An isolation variant, chosen by a parameter, is also available. It has a single accepting state in which each module may touch only its own range. In both variants, any request that the current state does not list is denied. The monitor then falls into a reject state that holds a violation flag until synchronous reset.

Top module: `mpm_access_monitor`

## Requirements
- R1: After synchronous reset (`rst` high at a clock edge), `grant`, `deny` and `violation` are 0 and the initial permission set applies. A request presented while `rst` is high is ignored.
- R2: A request with `req_valid` high is answered one cycle later by exactly one of `grant` or `deny`, each a one-cycle pulse. With `req_valid` low, both stay 0 on the next cycle.
- R3: In the initial set, module 1 (`module_id`=0) may read range 1 (`range_hit`=2'b01) and read range 2 (`range_hit`=2'b10). Module 2 (`module_id`=1) may read and write both ranges (`op_write`=1 means write).
- R4: A write by module 1 to range 1 is trigger A. It is granted. From the initial set it moves, from the next request on, to a set in which module 1 reads and writes range 1 and reads range 2, and module 2 only writes range 1 and reads and writes range 2.
- R5: A write by module 1 to range 2 is trigger B. It is granted. From the initial set it moves to a set in which module 1 reads range 1 and reads and writes range 2, and module 2 only writes both ranges.
- R6: After both triggers, in either order, module 1 may read and write both ranges and module 2 may only write both ranges.
- R7: A trigger presented again in a state where it is already permitted is granted and leaves the permission set unchanged.
- R8: A request whose `range_hit` does not have exactly one flag set is denied and enters the reject state.
- R9: A denial enters the reject state. There `violation` is 1, and every later request is denied until reset.
- R10: With `ISOLATION`=1, module 1 may read and write only range 1 and module 2 only range 2. Trigger writes have no special effect, and any other access is denied and rejects.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | A request is presented this cycle |
| module_id | input | 1 | Requester: 0 = module 1, 1 = module 2 |
| op_write | input | 1 | 1 = write, 0 = read |
| range_hit | input | NUM_RANGES | Range hit flags: bit 0 = range 1, bit 1 = range 2 |
| grant | output | 1 | Request of the previous cycle was allowed |
| deny | output | 1 | Request of the previous cycle was refused |
| violation | output | 1 | Sticky reject state indicator |

## Verification
Granting a request and changing the permission set happen in the same cycle when a trigger write arrives. The trigger itself must be granted under the old set, and the very next request must be judged under the new one. The bench provokes this by placing a request right after each trigger whose verdict differs between the two sets, for example a read of range 1 by module 2 just after trigger A. It checks both the trigger's grant and the follow-up verdict, reaching the final set through each of the two trigger orders.

// File: rtl/mpm_pkg.sv
package mpm_pkg;

    // Policy automaton states; ST_REJECT is absorbing until reset
    typedef enum logic [2:0] {
        ST_BASE   = 3'd0,
        ST_TRIG_A = 3'd1,
        ST_TRIG_B = 3'd2,
        ST_FINAL  = 3'd3,
        ST_REJECT = 3'd4
    } pol_state_e;

    typedef struct packed {
        logic rd;
        logic wr;
    } rights_t;

    typedef struct packed {
        pol_state_e state;
        logic       grant;
        logic       deny;
    } fsm_regs_t;

endpackage

// File: rtl/mpm_req_decode.sv
module mpm_req_decode #(
    parameter int NUM_RANGES = 2,
    localparam int RIDX_W    = (NUM_RANGES > 1) ? $clog2(NUM_RANGES) : 1
) (
    input  logic [NUM_RANGES-1:0] range_hit,
    output logic                  hit_ok,
    output logic [RIDX_W-1:0]     ridx
);

    logic single_d;

    always_comb begin
        ridx = '0;
        for (int i = 0; i < NUM_RANGES; i++) begin
            if (range_hit[i]) ridx = RIDX_W'(i);
        end
        single_d = $onehot(range_hit);
        // only ranges 1 and 2 are covered by the policy
        hit_ok   = single_d && ((ridx >> 1) == '0);
    end

endmodule

// File: rtl/mpm_rights.sv
module mpm_rights
    import mpm_pkg::*;
#(
    parameter bit ISOLATION = 1'b0,
    parameter int RIDX_W    = 1
) (
    input  pol_state_e        state,
    input  logic              module_id,
    input  logic [RIDX_W-1:0] ridx,
    output rights_t           rights
);

    logic second_range;
    assign second_range = ridx[0];

    generate
        if (ISOLATION) begin : g_iso
            always_comb begin
                rights.rd = (state != ST_REJECT) && (second_range == module_id);
                rights.wr = rights.rd;
            end
        end else begin : g_stateful
            // key = {state, requester, range}; each case lists {rd, wr}
            always_comb begin
                case ({state, module_id, second_range})
                    {ST_BASE,   1'b0, 1'b0}: rights = '{rd: 1'b1, wr: 1'b0};
                    {ST_BASE,   1'b0, 1'b1}: rights = '{rd: 1'b1, wr: 1'b0};
                    {ST_BASE,   1'b1, 1'b0}: rights = '{rd: 1'b1, wr: 1'b1};
                    {ST_BASE,   1'b1, 1'b1}: rights = '{rd: 1'b1, wr: 1'b1};
                    {ST_TRIG_A, 1'b0, 1'b0}: rights = '{rd: 1'b1, wr: 1'b1};
                    {ST_TRIG_A, 1'b0, 1'b1}: rights = '{rd: 1'b1, wr: 1'b0};
                    {ST_TRIG_A, 1'b1, 1'b0}: rights = '{rd: 1'b0, wr: 1'b1};
                    {ST_TRIG_A, 1'b1, 1'b1}: rights = '{rd: 1'b1, wr: 1'b1};
                    {ST_TRIG_B, 1'b0, 1'b0}: rights = '{rd: 1'b1, wr: 1'b0};
                    {ST_TRIG_B, 1'b0, 1'b1}: rights = '{rd: 1'b1, wr: 1'b1};
                    {ST_TRIG_B, 1'b1, 1'b0}: rights = '{rd: 1'b0, wr: 1'b1};
                    {ST_TRIG_B, 1'b1, 1'b1}: rights = '{rd: 1'b0, wr: 1'b1};
                    {ST_FINAL,  1'b0, 1'b0}: rights = '{rd: 1'b1, wr: 1'b1};
                    {ST_FINAL,  1'b0, 1'b1}: rights = '{rd: 1'b1, wr: 1'b1};
                    {ST_FINAL,  1'b1, 1'b0}: rights = '{rd: 1'b0, wr: 1'b1};
                    {ST_FINAL,  1'b1, 1'b1}: rights = '{rd: 1'b0, wr: 1'b1};
                    default:                 rights = '{rd: 1'b0, wr: 1'b0};
                endcase
            end
        end
    endgenerate

endmodule

// File: rtl/mpm_policy_fsm.sv
module mpm_policy_fsm
    import mpm_pkg::*;
#(
    parameter bit ISOLATION = 1'b0,
    parameter int RIDX_W    = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              module_id,
    input  logic              op_write,
    input  logic              hit_ok,
    input  logic [RIDX_W-1:0] ridx,
    input  rights_t           rights,
    output pol_state_e        state_q,
    output logic              grant_q,
    output logic              deny_q
);

    fsm_regs_t q, d;
    logic trig_a, trig_b, allowed;

    always_comb begin
        trig_a  = !ISOLATION && !module_id && op_write && hit_ok && !ridx[0];
        trig_b  = !ISOLATION && !module_id && op_write && hit_ok &&  ridx[0];
        allowed = hit_ok && (op_write ? rights.wr : rights.rd);

        d       = q;
        d.grant = 1'b0;
        d.deny  = 1'b0;
        if (req_valid) begin
            if (q.state == ST_REJECT) begin
                d.deny = 1'b1;
            end else if (trig_a) begin
                d.grant = 1'b1;
                case (q.state)
                    ST_BASE:   d.state = ST_TRIG_A;
                    ST_TRIG_B: d.state = ST_FINAL;
                    default:   d.state = q.state;
                endcase
            end else if (trig_b) begin
                d.grant = 1'b1;
                case (q.state)
                    ST_BASE:   d.state = ST_TRIG_B;
                    ST_TRIG_A: d.state = ST_FINAL;
                    default:   d.state = q.state;
                endcase
            end else if (allowed) begin
                d.grant = 1'b1;
            end else begin
                d.deny  = 1'b1;
                d.state = ST_REJECT;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '{state: ST_BASE, grant: 1'b0, deny: 1'b0};
        else     q <= d;
    end

    assign state_q = q.state;
    assign grant_q = q.grant;
    assign deny_q  = q.deny;

    // R2: verdicts are exclusive, answered and quiet when idle
    p_resp_excl_r2: assert property (@(posedge clk) disable iff (rst)
        $onehot0({grant_q, deny_q}));
    p_answered_r2: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> (grant_q || deny_q));
    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> (!grant_q && !deny_q));
    // R9: reject state absorbs and refuses
    p_reject_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_REJECT) |=> (state_q == ST_REJECT));
    p_reject_denies_r9: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_REJECT && req_valid) |=> deny_q);
    // R8: malformed range flags are refused
    p_bad_range_r8: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !hit_ok) |=> deny_q);
    // R4 / R5: trigger writes are granted outside reject
    p_trig_a_grant_r4: assert property (@(posedge clk) disable iff (rst)
        (req_valid && trig_a && state_q != ST_REJECT) |=> grant_q);
    p_trig_b_grant_r5: assert property (@(posedge clk) disable iff (rst)
        (req_valid && trig_b && state_q != ST_REJECT) |=> grant_q);
    // R6: in the final set module 2 cannot read
    p_final_no_read_r6: assert property (@(posedge clk) disable iff (rst)
        (req_valid && state_q == ST_FINAL && module_id && !op_write) |=> deny_q);
    // R10: isolation refuses the other module's range
    p_iso_cross_r10: assert property (@(posedge clk) disable iff (rst)
        (ISOLATION && req_valid && hit_ok && (ridx[0] != module_id)) |=> deny_q);

endmodule

// File: rtl/mpm_access_monitor.sv
module mpm_access_monitor
    import mpm_pkg::*;
#(
    parameter int NUM_RANGES = 2,
    parameter bit ISOLATION  = 1'b0
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  req_valid,
    input  logic                  module_id,
    input  logic                  op_write,
    input  logic [NUM_RANGES-1:0] range_hit,
    output logic                  grant,
    output logic                  deny,
    output logic                  violation
);

    localparam int RIDX_W = (NUM_RANGES > 1) ? $clog2(NUM_RANGES) : 1;

    logic              hit_ok;
    logic [RIDX_W-1:0] ridx;
    rights_t           rights;
    pol_state_e        state_q;

    mpm_req_decode #(.NUM_RANGES(NUM_RANGES)) u_decode (
        .range_hit (range_hit),
        .hit_ok    (hit_ok),
        .ridx      (ridx)
    );

    mpm_rights #(.ISOLATION(ISOLATION), .RIDX_W(RIDX_W)) u_rights (
        .state     (state_q),
        .module_id (module_id),
        .ridx      (ridx),
        .rights    (rights)
    );

    mpm_policy_fsm #(.ISOLATION(ISOLATION), .RIDX_W(RIDX_W)) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .module_id (module_id),
        .op_write  (op_write),
        .hit_ok    (hit_ok),
        .ridx      (ridx),
        .rights    (rights),
        .state_q   (state_q),
        .grant_q   (grant),
        .deny_q    (deny)
    );

    assign violation = (state_q == ST_REJECT);

    // R9: the violation flag only clears through reset
    p_violation_hold_r9: assert property (@(posedge clk) disable iff (rst)
        violation |=> violation);

endmodule

// File: tb/mpm_access_monitor_tb.sv
`timescale 1ns/1ps
module mpm_access_monitor_tb;

    logic       clk = 1'b0;
    logic       rst, req_valid, module_id, op_write;
    logic [1:0] range_hit;
    logic       grant, deny, violation;
    logic       g_iso, d_iso, v_iso;
    int         n_vec = 0, n_bad = 0;
    bit         done = 1'b0;

    always #2.5 clk = ~clk;

    mpm_access_monitor u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .module_id(module_id),
        .op_write(op_write), .range_hit(range_hit),
        .grant(grant), .deny(deny), .violation(violation));

    mpm_access_monitor #(.ISOLATION(1'b1)) u_iso (
        .clk(clk), .rst(rst), .req_valid(req_valid), .module_id(module_id),
        .op_write(op_write), .range_hit(range_hit),
        .grant(g_iso), .deny(d_iso), .violation(v_iso));

    // {req[3:0], rst, valid, module_id, write, range[1:0], exp grant, exp deny, exp violation}
    localparam int NV = 41;
    localparam logic [12:0] VEC [NV] = '{
        13'b0011_0_1_0_0_01_1_0_0, // R3 m1 read r1
        13'b0011_0_1_1_1_01_1_0_0, // R3 m2 write r1
        13'b0011_0_1_0_0_10_1_0_0, // R3 m1 read r2
        13'b0011_0_1_1_0_10_1_0_0, // R3 m2 read r2
        13'b0010_0_0_0_0_00_0_0_0, // R2 idle
        13'b0100_0_1_0_1_01_1_0_0, // R4 trigger A
        13'b0111_0_1_0_1_01_1_0_0, // R7 trigger A again
        13'b0100_0_1_1_0_10_1_0_0, // R4 m2 read r2
        13'b0100_0_1_0_0_10_1_0_0, // R4 m1 read r2
        13'b0100_0_1_1_1_01_1_0_0, // R4 m2 write r1
        13'b0110_0_1_0_1_10_1_0_0, // R6 trigger B after A
        13'b0111_0_1_0_1_10_1_0_0, // R7 trigger B again
        13'b0110_0_1_0_0_01_1_0_0, // R6 m1 read r1
        13'b0110_0_1_1_1_10_1_0_0, // R6 m2 write r2
        13'b0110_0_1_1_0_01_0_1_1, // R6 m2 read r1 refused
        13'b1001_0_1_0_0_01_0_1_1, // R9 later legal request refused
        13'b1001_0_0_0_0_00_0_0_1, // R9 idle keeps flag
        13'b1001_0_1_1_1_10_0_1_1, // R9 refused again
        13'b0001_1_0_0_0_00_0_0_0, // R1 reset
        13'b0101_0_1_0_1_10_1_0_0, // R5 trigger B
        13'b0101_0_1_1_1_01_1_0_0, // R5 m2 write r1
        13'b0110_0_1_0_1_01_1_0_0, // R6 trigger A after B
        13'b0110_0_1_0_1_10_1_0_0, // R6 m1 write r2
        13'b0110_0_1_1_1_01_1_0_0, // R6 m2 write r1
        13'b0110_0_1_1_0_10_0_1_1, // R6 m2 read r2 refused
        13'b0001_1_0_0_0_00_0_0_0, // R1 reset
        13'b0101_0_1_0_1_10_1_0_0, // R5 trigger B
        13'b0101_0_1_0_0_01_1_0_0, // R5 m1 read r1
        13'b0101_0_1_1_0_10_0_1_1, // R5 m2 read r2 refused
        13'b0001_1_0_0_0_00_0_0_0, // R1 reset
        13'b0100_0_1_0_1_01_1_0_0, // R4 trigger A
        13'b0100_0_1_1_0_01_0_1_1, // R4 m2 read r1 refused next request
        13'b0001_1_0_0_0_00_0_0_0, // R1 reset
        13'b1000_0_1_0_0_11_0_1_1, // R8 two flags
        13'b0001_1_0_0_0_00_0_0_0, // R1 reset
        13'b1000_0_1_1_1_00_0_1_1, // R8 no flag
        13'b0001_1_1_1_0_01_0_0_0, // R1 request during reset ignored
        13'b0011_0_1_1_0_01_1_0_0, // R3 m2 read r1 still base
        13'b0001_1_1_0_1_01_0_0_0, // R1 trigger during reset ignored
        13'b0011_0_1_1_0_01_1_0_0, // R3 m2 read r1 proves base kept
        13'b0010_0_0_1_1_10_0_0_0  // R2 idle with stray fields
    };

    task automatic drive(input logic r, input logic v, input logic m,
                         input logic w, input logic [1:0] h);
        rst = r; req_valid = v; module_id = m; op_write = w; range_hit = h;
        @(negedge clk);
    endtask

    task automatic judge(input int req, input logic [2:0] act, input logic [2:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL R%0d: grant/deny/violation = %b, expected %b", req, act, exp);
        end
    endtask

    initial begin
        drive(1'b1, 1'b0, 1'b0, 1'b0, 2'b00);
        drive(1'b1, 1'b0, 1'b0, 1'b0, 2'b00);
        // R1 reset state for both variants
        judge(1, {grant, deny, violation}, 3'b000);
        judge(1, {g_iso, d_iso, v_iso}, 3'b000);

        for (int i = 0; i < NV; i++) begin
            drive(VEC[i][8], VEC[i][7], VEC[i][6], VEC[i][5], VEC[i][4:3]);
            judge(int'(VEC[i][12:9]), {grant, deny, violation}, VEC[i][2:0]);
        end

        // R10 isolation variant, directed
        drive(1'b1, 1'b0, 1'b0, 1'b0, 2'b00);
        drive(1'b0, 1'b1, 1'b0, 1'b1, 2'b01);
        judge(10, {g_iso, d_iso, v_iso}, 3'b100); // m1 write r1
        drive(1'b0, 1'b1, 1'b0, 1'b0, 2'b01);
        judge(10, {g_iso, d_iso, v_iso}, 3'b100); // m1 read r1
        drive(1'b0, 1'b1, 1'b1, 1'b1, 2'b10);
        judge(10, {g_iso, d_iso, v_iso}, 3'b100); // m2 write r2
        drive(1'b0, 1'b1, 1'b1, 1'b0, 2'b10);
        judge(10, {g_iso, d_iso, v_iso}, 3'b100); // m2 read r2
        drive(1'b0, 1'b1, 1'b0, 1'b1, 2'b10);
        judge(10, {g_iso, d_iso, v_iso}, 3'b011); // m1 write r2: no trigger, refused
        drive(1'b0, 1'b1, 1'b0, 1'b0, 2'b01);
        judge(10, {g_iso, d_iso, v_iso}, 3'b011); // sticky after refusal
        drive(1'b1, 1'b0, 1'b0, 1'b0, 2'b00);
        drive(1'b0, 1'b1, 1'b1, 1'b0, 2'b01);
        judge(10, {g_iso, d_iso, v_iso}, 3'b011); // m2 read r1 refused

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL R2: watchdog expired, actual running, expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule